// File: doc/BRIEF.md
# Multi-mode panel row timing generator

This block produces the row-side drive pulses for a line-addressed display panel. It runs on the pixel-rate master clock and is paced by a line strobe that marks the start of every line. A frame-start flag that arrives together with a line strobe opens a new frame. On each frame start the block captures the configuration for the whole frame. That configuration is a 3-bit mode code that picks how many rows are scanned, a scan-direction bit, and five master-clock positions that place the sub-line events inside every line.

Inside the scan window, each line carries the same sequence of events: an edge of the row shift clock, a rising then falling gate enable, and a precharge pulse. The row start pulse covers a whole line near the top of the frame, and the line it sits on depends on the scan direction. In every mode except the full-height one, a one-line black-frame pulse opens the frame and is also merged into the precharge output. A polarity flag flips on every line so that the data path can invert the drive on alternate lines.

Top module: `row_timing_gen`

## Requirements
- R1: After a synchronous active-high reset every output is low. Until the first line strobe that carries the frame-start flag, no start, shift-clock, enable, precharge or black-frame activity appears. The polarity flag still flips on each line strobe.
- R2: The mode code sets the number of scanned rows N: 0→624, 1→600, 2→572, 3→480, 4→400, 5→480, and 6 and 7→624. The shift clock therefore changes level exactly N times per frame.
- R3: Frame lines are numbered from 0, where line 0 is the line whose strobe carries the frame-start flag. The scan window is lines S to S+N-1, with S=2 when the direction bit is 0 and S=3 when it is 1. In each window line the shift clock toggles in cycle k = vck_at+1. Here k counts the cycles after the strobe-sampling edge, and k=0 is the cycle right after that edge. Outside the window the shift clock holds its level.
- R4: In window lines the gate enable is high for enb_on_at < k ≤ enb_off_at, provided enb_on_at < enb_off_at.
- R5: The precharge output is high for pch_on_at < k ≤ pch_on_at+pch_len in window lines, ORed with the black-frame pulse.
- R6: The black-frame output is high for the whole of line 0 when N≠624, and it stays low in the 624-row modes.
- R7: The start pulse is high for the whole of line S. This places it one line after the black-frame pulse falls when the direction bit is 0, and two lines after when the direction bit is 1.
- R8: The polarity flag toggles in the cycle after every line strobe.
- R9: Mode, direction and the five positions are captured only at a frame start. Changes made mid-frame first act in the next frame. A frame-start flag without a line strobe is ignored.
- R10: A line strobe takes priority over an event that falls on the same cycle. Enable and precharge are cleared, and a shift-clock edge due in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle line start strobe |
| frame_stb | input | 1 | Frame start flag, honoured only with line_stb |
| mode_sel | input | 3 | Row-count mode code |
| scan_up | input | 1 | Scan direction (0 down, 1 up) |
| vck_at | input | 12 | Shift-clock edge position in the line |
| enb_on_at | input | 12 | Gate enable rise position |
| enb_off_at | input | 12 | Gate enable fall position |
| pch_on_at | input | 12 | Precharge rise position |
| pch_len | input | 12 | Precharge width in cycles |
| vst_o | output | 1 | Row start pulse |
| vck_o | output | 1 | Row shift clock |
| gate_en_o | output | 1 | Gate enable |
| pch_o | output | 1 | Precharge pulse ORed with black-frame |
| blk_o | output | 1 | Black-frame pulse |
| pol_o | output | 1 | Line polarity flag |

## Verification
A line strobe can land in the same cycle as a sub-line event. When that happens, the restart of the line competes with a shift-clock toggle or with a pulse that is still high. The bench provokes this by shortening some window lines. In one group the strobe falls exactly on the shift-clock position, so the edge must vanish. In another group the strobe cuts the precharge pulse two cycles after it rises, so the pulse must end at the strobe. The per-cycle reference model, which restarts its own line count at every strobe, decides both outcomes.

// File: rtl/row_timing_pkg.sv
`timescale 1ns/1ps
package row_timing_pkg;
  localparam int POS_W      = 12;
  localparam int LINE_W     = 11;
  localparam int FULL_LINES = 624;
  localparam int DOWN_FIRST = 2;
  localparam int UP_FIRST   = 3;

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [LINE_W-1:0] line_t;

  typedef struct packed {
    pos_t vck_at;
    pos_t enb_on_at;
    pos_t enb_off_at;
    pos_t pch_on_at;
    pos_t pch_len;
  } pos_cfg_t;

  // rows scanned for each mode code; unused codes fall back to full height
  function automatic line_t lines_for_mode(input logic [2:0] m);
    case (m)
      3'd1:    return line_t'(600);
      3'd2:    return line_t'(572);
      3'd3:    return line_t'(480);
      3'd4:    return line_t'(400);
      3'd5:    return line_t'(480);
      default: return line_t'(FULL_LINES);
    endcase
  endfunction

  // first scanned line of the frame for a direction
  function automatic line_t first_row(input logic up);
    return up ? line_t'(UP_FIRST) : line_t'(DOWN_FIRST);
  endfunction

  // cycle at which a pulse started at `start` ends, one bit wider
  function automatic logic [POS_W:0] pulse_end(input pos_t start, input pos_t len);
    return {1'b0, start} + {1'b0, len};
  endfunction
endpackage

// File: rtl/line_timer.sv
`timescale 1ns/1ps
module line_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] cyc
);
  localparam logic [W-1:0] CYC_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                 cyc <= '0;
    else if (restart)        cyc <= '0;
    else if (cyc != CYC_MAX) cyc <= cyc + 1'b1;
  end
endmodule

// File: rtl/frame_seq.sv
`timescale 1ns/1ps
module frame_seq
  import row_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_stb,
  input  logic       frame_stb,
  input  logic [2:0] mode_sel,
  input  logic       scan_up,
  input  pos_cfg_t   pos_in,
  output logic       armed,
  output pos_cfg_t   pos_q,
  output line_t      lines_q,
  output logic       full_q,
  output logic       in_win,
  output logic       vst_q,
  output logic       blk_q,
  output logic       pol_q
);
  localparam line_t IDX_MAX = '1;

  line_t           line_idx;
  line_t           next_idx;
  line_t           win_lo;
  logic [LINE_W:0] win_hi;
  logic            up_q;
  logic            frame_go;
  logic            next_up;
  logic            next_full;

  always_comb begin
    frame_go  = line_stb & frame_stb;
    next_up   = frame_go ? scan_up : up_q;
    next_full = frame_go ? (lines_for_mode(mode_sel) == line_t'(FULL_LINES)) : full_q;
    if (frame_go)                 next_idx = '0;
    else if (line_idx == IDX_MAX) next_idx = line_idx;
    else                          next_idx = line_idx + 1'b1;
    win_lo = first_row(up_q);
    win_hi = {1'b0, win_lo} + {1'b0, lines_q};
    in_win = armed && (line_idx >= win_lo) && ({1'b0, line_idx} < win_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      line_idx <= '0;
      pos_q    <= '0;
      lines_q  <= line_t'(FULL_LINES);
      full_q   <= 1'b1;
      up_q     <= 1'b0;
      vst_q    <= 1'b0;
      blk_q    <= 1'b0;
      pol_q    <= 1'b0;
    end else begin
      if (line_stb) pol_q <= ~pol_q;
      if (frame_go) begin
        armed   <= 1'b1;
        pos_q   <= pos_in;
        lines_q <= lines_for_mode(mode_sel);
        full_q  <= next_full;
        up_q    <= scan_up;
      end
      if (line_stb && (armed || frame_go)) begin
        line_idx <= next_idx;
        vst_q    <= (next_idx == first_row(next_up));
        blk_q    <= (next_idx == '0) && !next_full;
      end
    end
  end
endmodule

// File: rtl/pulse_gen.sv
`timescale 1ns/1ps
module pulse_gen
  import row_timing_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     line_stb,
  input  logic     in_win,
  input  pos_t     cyc,
  input  pos_cfg_t pos_q,
  output logic     vck_q,
  output logic     enb_q,
  output logic     pch_q
);
  logic [POS_W:0] pch_stop;
  logic           vck_hit;
  logic           enb_set;
  logic           enb_clr;
  logic           pch_set;
  logic           pch_clr;

  always_comb begin
    pch_stop = pulse_end(pos_q.pch_on_at, pos_q.pch_len);
    vck_hit  = in_win && !line_stb && (cyc == pos_q.vck_at);
    enb_set  = in_win && !line_stb && (cyc == pos_q.enb_on_at);
    enb_clr  = line_stb || (cyc == pos_q.enb_off_at);
    pch_set  = in_win && !line_stb && (cyc == pos_q.pch_on_at);
    pch_clr  = line_stb || ({1'b0, cyc} == pch_stop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vck_q <= 1'b0;
      enb_q <= 1'b0;
      pch_q <= 1'b0;
    end else begin
      if (vck_hit) vck_q <= ~vck_q;
      if (enb_clr)      enb_q <= 1'b0;
      else if (enb_set) enb_q <= 1'b1;
      if (pch_clr)      pch_q <= 1'b0;
      else if (pch_set) pch_q <= 1'b1;
    end
  end
endmodule

// File: rtl/row_timing_gen.sv
`timescale 1ns/1ps
module row_timing_gen
  import row_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             line_stb,
  input  logic             frame_stb,
  input  logic [2:0]       mode_sel,
  input  logic             scan_up,
  input  logic [POS_W-1:0] vck_at,
  input  logic [POS_W-1:0] enb_on_at,
  input  logic [POS_W-1:0] enb_off_at,
  input  logic [POS_W-1:0] pch_on_at,
  input  logic [POS_W-1:0] pch_len,
  output logic             vst_o,
  output logic             vck_o,
  output logic             gate_en_o,
  output logic             pch_o,
  output logic             blk_o,
  output logic             pol_o
);
  pos_cfg_t pos_in;
  pos_cfg_t pos_q;
  pos_t     cyc;
  line_t    cfg_lines;
  logic     armed;
  logic     full_q;
  logic     in_win;
  logic     vst_q;
  logic     blk_q;
  logic     pol_q;
  logic     vck_q;
  logic     enb_q;
  logic     pchp_q;

  assign pos_in = {vck_at, enb_on_at, enb_off_at, pch_on_at, pch_len};

  line_timer #(.W(POS_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (line_stb),
    .cyc     (cyc)
  );

  frame_seq u_frame (
    .clk       (clk),
    .rst       (rst),
    .line_stb  (line_stb),
    .frame_stb (frame_stb),
    .mode_sel  (mode_sel),
    .scan_up   (scan_up),
    .pos_in    (pos_in),
    .armed     (armed),
    .pos_q     (pos_q),
    .lines_q   (cfg_lines),
    .full_q    (full_q),
    .in_win    (in_win),
    .vst_q     (vst_q),
    .blk_q     (blk_q),
    .pol_q     (pol_q)
  );

  pulse_gen u_pulse (
    .clk      (clk),
    .rst      (rst),
    .line_stb (line_stb),
    .in_win   (in_win),
    .cyc      (cyc),
    .pos_q    (pos_q),
    .vck_q    (vck_q),
    .enb_q    (enb_q),
    .pch_q    (pchp_q)
  );

  assign vst_o     = vst_q;
  assign vck_o     = vck_q;
  assign gate_en_o = enb_q;
  assign pch_o     = pchp_q | blk_q;
  assign blk_o     = blk_q;
  assign pol_o     = pol_q;
endmodule

// File: rtl/row_timing_chk.sv
`timescale 1ns/1ps
module row_timing_chk
  import row_timing_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  line_stb,
  input logic  frame_stb,
  input logic  vst_o,
  input logic  vck_o,
  input logic  gate_en_o,
  input logic  blk_o,
  input logic  pol_o,
  input logic  armed,
  input logic  in_win,
  input logic  full_q,
  input line_t cfg_lines
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!vst_o && !vck_o && !gate_en_o && !blk_o));

  // R3
  vck_window_chk: assert property (@(posedge clk) disable iff (rst)
    (vck_o != $past(vck_o)) |-> $past(in_win));

  // R4
  enb_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en_o) |-> $past(in_win));

  // R6
  blk_mode_chk: assert property (@(posedge clk) disable iff (rst)
    blk_o |-> !full_q);

  // R7
  vst_blk_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !(vst_o && blk_o));

  // R8
  pol_flip_chk: assert property (@(posedge clk) disable iff (rst)
    line_stb |=> (pol_o != $past(pol_o)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_stb && frame_stb) |=> $stable(cfg_lines));

  // R10
  strobe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    line_stb |=> !gate_en_o);
endmodule

bind row_timing_gen row_timing_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_stb  (line_stb),
  .frame_stb (frame_stb),
  .vst_o     (vst_o),
  .vck_o     (vck_o),
  .gate_en_o (gate_en_o),
  .blk_o     (blk_o),
  .pol_o     (pol_o),
  .armed     (armed),
  .in_win    (in_win),
  .full_q    (full_q),
  .cfg_lines (cfg_lines)
);

// File: tb/sim_row_timing_gen.sv
`timescale 1ns/1ps
module sim_row_timing_gen;
  import row_timing_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst = 1'b1;
  logic             ls = 1'b0;
  logic             fs = 1'b0;
  logic [2:0]       mode = 3'd0;
  logic             up = 1'b0;
  logic [POS_W-1:0] p_vck_in, p_on_in, p_off_in, p_pon_in, p_plen_in;
  logic vst_o, vck_o, gate_en_o, pch_o, blk_o, pol_o;

  row_timing_gen u0 (
    .clk(clk), .rst(rst), .line_stb(ls), .frame_stb(fs), .mode_sel(mode),
    .scan_up(up), .vck_at(p_vck_in), .enb_on_at(p_on_in), .enb_off_at(p_off_in),
    .pch_on_at(p_pon_in), .pch_len(p_plen_in),
    .vst_o(vst_o), .vck_o(vck_o), .gate_en_o(gate_en_o), .pch_o(pch_o),
    .blk_o(blk_o), .pol_o(pol_o)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string phase = "reset";
  bit    done = 1'b0;
  bit    skip_cnt = 1'b0;

  // reference model state
  bit m_armed, m_full, m_skip, e_pol, e_vck, prev_vck;
  int m_line, t, m_lines, m_first, obs_tog;
  int p_vck, p_on, p_off, p_pon, p_plen;

  function automatic int bench_lines(input int code);
    if (code == 1) return 600;
    if (code == 2) return 572;
    if (code == 3 || code == 5) return 480;
    if (code == 4) return 400;
    return 624;
  endfunction

  function automatic bit m_win();
    return m_armed && (m_line >= m_first) && (m_line < m_first + m_lines);
  endfunction

  function automatic void chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s [%s] got %0d exp %0d", req, what, phase, got, exp);
    end
  endfunction

  // behavioural model, advanced on each rising edge from the bench's own inputs
  always @(posedge clk) begin
    if (rst) begin
      m_armed = 0; m_line = 0; t = 0; e_pol = 0; e_vck = 0; obs_tog = 0;
    end else if (ls) begin
      e_pol = !e_pol;
      if (fs) begin
        if (m_armed && !m_skip) chk("R2", "shift-clock toggles per frame", obs_tog, m_lines);
        obs_tog = 0;
        m_armed = 1; m_line = 0;
        m_lines = bench_lines(int'(mode));
        m_full  = (m_lines == 624);
        m_first = up ? 3 : 2;
        p_vck = int'(p_vck_in); p_on = int'(p_on_in); p_off = int'(p_off_in);
        p_pon = int'(p_pon_in); p_plen = int'(p_plen_in);
        m_skip = skip_cnt;
      end else if (m_armed) begin
        m_line++;
      end
      t = 0;
    end else begin
      t++;
      if (m_win() && t == p_vck + 1) e_vck = !e_vck;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    bit xb, xv, xe, xpp;
    xb  = m_armed && m_line == 0 && !m_full;
    xv  = m_armed && m_line == m_first;
    xe  = m_win() && t > p_on && t <= p_off;
    xpp = m_win() && t > p_pon && t <= p_pon + p_plen;
    chk("R7", "vst", int'(vst_o), int'(xv));
    chk("R3", "vck", int'(vck_o), int'(e_vck));
    chk("R4", "gate_en", int'(gate_en_o), int'(xe));
    chk("R5", "pch", int'(pch_o), int'(xpp || xb));
    chk("R6", "blk", int'(blk_o), int'(xb));
    chk("R8", "pol", int'(pol_o), int'(e_pol));
    if (vck_o !== prev_vck) obs_tog++;
    prev_vck = vck_o;
  end

  task automatic send_line(input bit first, input int len, input bit lone);
    @(negedge clk); ls = 1'b1; fs = first;
    @(negedge clk); ls = 1'b0; fs = lone;
    for (int k = 2; k < len; k++) begin
      @(negedge clk); fs = 1'b0;
    end
  endtask

  // whole frame; kind 0 normal, 1 mid-frame changes (R9), 2 short lines (R10)
  task automatic run_frame(input logic [2:0] md, input bit dir, input int kind);
    int n;
    mode = md; up = dir;
    n = bench_lines(int'(md)) + 5;
    skip_cnt = (kind == 2);
    for (int ln = 0; ln < n; ln++) begin
      int len;
      len = 34;
      if (kind == 1 && ln == 10) begin
        mode = 3'd0; up = ~dir;
        p_vck_in = 12'd5; p_on_in = 12'd9; p_off_in = 12'd15;
        p_pon_in = 12'd18; p_plen_in = 12'd3;
      end
      if (kind == 2 && ln >= 10 && ln < 15) len = int'(p_vck_in) + 1;
      if (kind == 2 && ln >= 20 && ln < 25) len = int'(p_pon_in) + 3;
      send_line(ln == 0, len, kind == 1 && ln == 30);
    end
  endtask

  initial begin
    p_vck_in = 12'd3; p_on_in = 12'd6; p_off_in = 12'd20;
    p_pon_in = 12'd24; p_plen_in = 12'd6;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    phase = "R1 after reset";
    chk("R1", "reset vst", int'(vst_o), 0);
    chk("R1", "reset vck", int'(vck_o), 0);
    chk("R1", "reset gate_en", int'(gate_en_o), 0);
    chk("R1", "reset pch", int'(pch_o), 0);
    chk("R1", "reset blk", int'(blk_o), 0);
    chk("R1", "reset pol", int'(pol_o), 0);
    for (int i = 0; i < 5; i++) send_line(1'b0, 34, 1'b0);
    chk("R1", "unarmed vck", int'(vck_o), 0);
    chk("R1", "unarmed pol after 5 lines", int'(pol_o), 1);

    phase = "R2 624 down";  run_frame(3'd0, 1'b0, 0);
    phase = "R2 480 up";    run_frame(3'd3, 1'b1, 0);
    phase = "R9 mid-frame"; run_frame(3'd4, 1'b0, 1);
    phase = "R2 code 7";    run_frame(3'd7, 1'b0, 0);
    phase = "R10 short";    run_frame(3'd5, 1'b1, 2);
    phase = "R2 572 down";  run_frame(3'd2, 1'b0, 0);
    phase = "R1 reset mid-frame";
    mode = 3'd1; up = 1'b0;
    send_line(1'b1, 34, 1'b0);
    for (int i = 0; i < 4; i++) send_line(1'b0, 34, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "re-reset blk", int'(blk_o), 0);
    chk("R1", "re-reset pol", int'(pol_o), 0);
    chk("R1", "re-reset vck", int'(vck_o), 0);
    for (int i = 0; i < 3; i++) send_line(1'b0, 34, 1'b0);
    chk("R1", "unarmed vst", int'(vst_o), 0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog [%s] got timeout exp completion", phase);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule